// File: doc/BRIEF.md
# Two-State Instruction Cache Line Controller

This block keeps the line state for a set-associative instruction cache whose lines are either empty or holding a copy of memory. Each line has only these two states and is never marked as modified. A CPU fetch is looked up against every way of the addressed set at once. A hit answers from the stored word one cycle later. A miss raises a line-fill request to memory, holds off further fetches, writes the returned word into a chosen way, and passes the same word back to the CPU.

Software-style maintenance commands remove lines: a per-line invalidate, a per-line push (equivalent here, as nothing is ever dirty) and a whole-cache invalidate. Bus activity by other masters is presented on a snoop-event input. This cache does not snoop, so those events never alter any line. A line leaves the valid state only through a command. A fill always lands in an empty way of the set when one exists; otherwise a free-running counter names the way to overwrite.

Top module: `icache_line_ctrl`

## Requirements
- R1: After reset every line is invalid, `fetch_ready_o` is 1, and `fetch_valid_o` and `fill_req_o` are 0.
- R2: A fetch accepted (request high while ready) whose tag matches a valid way of the set given by address bits [7:4] answers in the next cycle with `fetch_valid_o`=1, `fetch_hit_o`=1 and the stored word, and raises no fill. Address bits [3:0] are ignored.
- R3: An accepted fetch that misses raises `fill_req_o` in the next cycle with `fill_addr_o` = the fetch address with bits [3:0] cleared, and holds both until `fill_ack_i`. In the cycle after the ack, the block answers with `fetch_valid_o`=1, `fetch_hit_o`=0 and the `fill_data_i` word, and the line is then valid.
- R4: `fetch_ready_o` is 0 from the cycle after an accepted miss through the ack cycle, and 1 in every other cycle.
- R5: A fill writes the lowest-numbered invalid way of its set. If all four ways are valid, it writes way (number of clock edges since reset release before the ack edge) mod 4.
- R6: A line overwritten by a fill stays valid with the new tag and data, and the old address then misses.
- R7: `cmd_op_i`=01 (invalidate) or 10 (push) with `cmd_valid_i` clears only the valid line whose set and tag match `cmd_addr_i`. If no line matches, nothing changes. Op 00 does nothing.
- R8: `cmd_op_i`=11 with `cmd_valid_i` clears every line in a single cycle.
- R9: Snoop events, whether read or write and at any address, never change any line state.
- R10: A command is accepted in any cycle, including during a fill, and takes effect at the next edge. A fetch lookup in the same cycle sees the contents from before the command. A fill completing in the same cycle is written after the command and survives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_req_i | input | 1 | CPU fetch request |
| fetch_addr_i | input | 32 | Fetch byte address |
| fetch_ready_o | output | 1 | Fetch can be accepted this cycle |
| fetch_valid_o | output | 1 | Fetch response valid |
| fetch_hit_o | output | 1 | Response came from the cache (1) or from a fill (0) |
| fetch_data_o | output | 32 | Fetch response word |
| fill_req_o | output | 1 | Line-fill request to memory |
| fill_addr_o | output | 32 | Line-aligned fill address |
| fill_ack_i | input | 1 | Memory returns the line this cycle |
| fill_data_i | input | 32 | Returned line word |
| cmd_valid_i | input | 1 | Maintenance command strobe |
| cmd_op_i | input | 2 | 00 none, 01 invalidate line, 10 push line, 11 invalidate all |
| cmd_addr_i | input | 32 | Command line address |
| snoop_valid_i | input | 1 | Alternate-master bus event |
| snoop_write_i | input | 1 | Event is a write |
| snoop_addr_i | input | 32 | Event address |

## Verification
The main lookup path is driven with repeat fetches, with fetches that differ only in the byte offset, and with fetches of new tags into one set. These separate a true tag match from an offset-sensitive compare, and an empty-way fill from a counter-chosen replacement. Fill latencies of zero to three cycles separate a correct request hold from an early drop. Commands are issued alone, on absent lines, alongside a hitting fetch, and across a whole fill including the ack cycle. These patterns expose errors in the ordering between command and fill writes. Snoop reads and writes aimed at cached lines, followed by refetches that must still hit, show that bus events leave the lines alone.

// File: rtl/icl_pkg.sv
package icl_pkg;
  typedef enum logic [1:0] {
    CMD_NONE    = 2'b00,
    CMD_INV     = 2'b01,
    CMD_PUSH    = 2'b10,
    CMD_INV_ALL = 2'b11
  } cmd_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } state_e;
endpackage

// File: rtl/icl_tag_store.sv
module icl_tag_store #(
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  parameter int TAG_W  = 24,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  lk_idx_i,
  input  logic [TAG_W-1:0]  lk_tag_i,
  output logic              lk_hit_o,
  output logic [DATA_W-1:0] lk_data_o,
  input  logic [IDX_W-1:0]  vs_idx_i,
  output logic [WAYS-1:0]   vs_valid_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [WAY_W-1:0]  wr_way_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              inv_en_i,
  input  logic [IDX_W-1:0]  inv_idx_i,
  input  logic [TAG_W-1:0]  inv_tag_i,
  input  logic              inv_all_i
);
  logic [WAYS-1:0]   valid_q [SETS];
  logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
  logic [DATA_W-1:0] data_q  [SETS][WAYS];
  logic [WAYS-1:0]   inv_match;

  always_comb begin
    lk_hit_o  = 1'b0;
    lk_data_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (valid_q[lk_idx_i][w] && tag_q[lk_idx_i][w] == lk_tag_i) begin
        lk_hit_o  = 1'b1;
        lk_data_o = data_q[lk_idx_i][w];
      end
    end
  end

  assign vs_valid_o = valid_q[vs_idx_i];

  for (genvar w = 0; w < WAYS; w++) begin : g_inv
    assign inv_match[w] = valid_q[inv_idx_i][w] && (tag_q[inv_idx_i][w] == inv_tag_i);
  end

  // command clears first, a same-cycle fill write lands after it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else begin
      if (inv_all_i) begin
        for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
      end else if (inv_en_i) begin
        valid_q[inv_idx_i] <= valid_q[inv_idx_i] & ~inv_match;
      end
      if (wr_en_i) valid_q[wr_idx_i][wr_way_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_idx_i][wr_way_i]  <= wr_tag_i;
      data_q[wr_idx_i][wr_way_i] <= wr_data_i;
    end
  end
endmodule

// File: rtl/icl_victim.sv
module icl_victim #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WAYS-1:0]  valid_i,
  output logic [WAY_W-1:0] way_o
);
  logic [WAY_W-1:0] cnt_q;
  logic             found;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    way_o = cnt_q;
    found = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!valid_i[w] && !found) begin
        way_o = WAY_W'(w);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/icl_ctrl.sv
module icl_ctrl
  import icl_pkg::*;
#(
  parameter int TAG_W  = 24,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_req_i,
  input  logic [TAG_W-1:0]  fetch_tag_i,
  input  logic [IDX_W-1:0]  fetch_idx_i,
  input  logic              hit_i,
  input  logic [DATA_W-1:0] hit_data_i,
  input  logic              fill_ack_i,
  input  logic [DATA_W-1:0] fill_data_i,
  output logic              ready_o,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              fill_req_o,
  output logic [TAG_W-1:0]  fill_tag_o,
  output logic [IDX_W-1:0]  fill_idx_o,
  output logic              fill_done_o
);
  state_e state_q;
  logic   accept;

  assign ready_o     = (state_q == ST_IDLE);
  assign accept      = fetch_req_i && ready_o;
  assign fill_done_o = (state_q == ST_FILL) && fill_ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_data_o  <= '0;
      fill_req_o  <= 1'b0;
      fill_tag_o  <= '0;
      fill_idx_o  <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      if (accept && hit_i) begin
        rsp_valid_o <= 1'b1;
        rsp_hit_o   <= 1'b1;
        rsp_data_o  <= hit_data_i;
      end else if (accept) begin
        state_q    <= ST_FILL;
        fill_req_o <= 1'b1;
        fill_tag_o <= fetch_tag_i;
        fill_idx_o <= fetch_idx_i;
      end else if (fill_done_o) begin
        state_q     <= ST_IDLE;
        fill_req_o  <= 1'b0;
        rsp_valid_o <= 1'b1;
        rsp_hit_o   <= 1'b0;
        rsp_data_o  <= fill_data_i;
      end
    end
  end
endmodule

// File: rtl/icache_line_ctrl.sv
module icache_line_ctrl
  import icl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 4,
  parameter int SETS   = 16,
  parameter int WAYS   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_req_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  output logic              fetch_ready_o,
  output logic              fetch_valid_o,
  output logic              fetch_hit_o,
  output logic [DATA_W-1:0] fetch_data_o,
  output logic              fill_req_o,
  output logic [ADDR_W-1:0] fill_addr_o,
  input  logic              fill_ack_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic              snoop_valid_i,
  input  logic              snoop_write_i,
  input  logic [ADDR_W-1:0] snoop_addr_i
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam int WAY_W = $clog2(WAYS);

  logic [IDX_W-1:0]  f_idx, c_idx, fill_idx;
  logic [TAG_W-1:0]  f_tag, c_tag, fill_tag;
  logic              hit, fill_done, inv_en, inv_all;
  logic [DATA_W-1:0] hit_data;
  logic [WAYS-1:0]   set_valid;
  logic [WAY_W-1:0]  victim_way;
  cmd_e              op;
  logic              snoop_unused;

  assign f_idx = fetch_addr_i[OFF_W +: IDX_W];
  assign f_tag = fetch_addr_i[ADDR_W-1 -: TAG_W];
  assign c_idx = cmd_addr_i[OFF_W +: IDX_W];
  assign c_tag = cmd_addr_i[ADDR_W-1 -: TAG_W];

  assign op      = cmd_e'(cmd_op_i);
  assign inv_en  = cmd_valid_i && (op == CMD_INV || op == CMD_PUSH);
  assign inv_all = cmd_valid_i && (op == CMD_INV_ALL);

  // not a snooping cache: bus events and byte offsets go nowhere
  assign snoop_unused = ^{snoop_valid_i, snoop_write_i, snoop_addr_i,
                          fetch_addr_i[OFF_W-1:0], cmd_addr_i[OFF_W-1:0]};

  assign fill_addr_o = {fill_tag, fill_idx, {OFF_W{1'b0}}};

  icl_tag_store #(
    .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lk_idx_i   (f_idx),
    .lk_tag_i   (f_tag),
    .lk_hit_o   (hit),
    .lk_data_o  (hit_data),
    .vs_idx_i   (fill_idx),
    .vs_valid_o (set_valid),
    .wr_en_i    (fill_done),
    .wr_idx_i   (fill_idx),
    .wr_way_i   (victim_way),
    .wr_tag_i   (fill_tag),
    .wr_data_i  (fill_data_i),
    .inv_en_i   (inv_en),
    .inv_idx_i  (c_idx),
    .inv_tag_i  (c_tag),
    .inv_all_i  (inv_all)
  );

  icl_victim #(.WAYS(WAYS)) u_victim (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (set_valid),
    .way_o   (victim_way)
  );

  icl_ctrl #(.TAG_W(TAG_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fetch_req_i (fetch_req_i),
    .fetch_tag_i (f_tag),
    .fetch_idx_i (f_idx),
    .hit_i       (hit),
    .hit_data_i  (hit_data),
    .fill_ack_i  (fill_ack_i),
    .fill_data_i (fill_data_i),
    .ready_o     (fetch_ready_o),
    .rsp_valid_o (fetch_valid_o),
    .rsp_hit_o   (fetch_hit_o),
    .rsp_data_o  (fetch_data_o),
    .fill_req_o  (fill_req_o),
    .fill_tag_o  (fill_tag),
    .fill_idx_o  (fill_idx),
    .fill_done_o (fill_done)
  );
endmodule

// File: rtl/icl_checker.sv
module icl_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fetch_req_i,
  input logic              fetch_ready_o,
  input logic              fetch_valid_o,
  input logic              fetch_hit_o,
  input logic [DATA_W-1:0] fetch_data_o,
  input logic              fill_req_o,
  input logic [ADDR_W-1:0] fill_addr_o,
  input logic              fill_ack_i,
  input logic [DATA_W-1:0] fill_data_i
);
  assert_fill_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_req_o && !fill_ack_i |=> fill_req_o && $stable(fill_addr_o));

  assert_fill_rsp_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_req_o && fill_ack_i |=> fetch_valid_o && !fetch_hit_o
                                 && fetch_data_o == $past(fill_data_i));

  assert_ready_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_req_o |-> !fetch_ready_o);

  assert_ready_back_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_req_o && fill_ack_i |=> fetch_ready_o && !fill_req_o);

  assert_rsp_source_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_o |-> $past(fetch_req_i && fetch_ready_o) || $past(fill_req_o && fill_ack_i));

  assert_hit_nofill_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_o && fetch_hit_o |-> !fill_req_o);
endmodule

bind icache_line_ctrl icl_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .fetch_req_i   (fetch_req_i),
  .fetch_ready_o (fetch_ready_o),
  .fetch_valid_o (fetch_valid_o),
  .fetch_hit_o   (fetch_hit_o),
  .fetch_data_o  (fetch_data_o),
  .fill_req_o    (fill_req_o),
  .fill_addr_o   (fill_addr_o),
  .fill_ack_i    (fill_ack_i),
  .fill_data_i   (fill_data_i)
);

// File: tb/icache_line_ctrl_tb.sv
`timescale 1ns/1ps
module icache_line_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fetch_req_i = 1'b0;
  logic [31:0] fetch_addr_i = '0;
  logic        fetch_ready_o, fetch_valid_o, fetch_hit_o;
  logic [31:0] fetch_data_o;
  logic        fill_req_o;
  logic [31:0] fill_addr_o;
  logic        fill_ack_i = 1'b0;
  logic [31:0] fill_data_i = '0;
  logic        cmd_valid_i = 1'b0;
  logic [1:0]  cmd_op_i = 2'b00;
  logic [31:0] cmd_addr_i = '0;
  logic        snoop_valid_i = 1'b0;
  logic        snoop_write_i = 1'b0;
  logic [31:0] snoop_addr_i = '0;

  always #5 clk_i = ~clk_i;

  icache_line_ctrl u_dut (.*);

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;
  string phase  = "R1";

  // reference model
  bit        m_val [16][4];
  bit [23:0] m_tag [16][4];
  bit [31:0] m_dat [16][4];
  int        m_cnt = 0;
  bit        m_fill = 0;
  bit [31:0] m_faddr = '0;
  bit        e_rv = 0, e_hit = 0;
  bit [31:0] e_data = '0;
  int        lat = 0, wait_n = 0;

  function automatic bit [31:0] mem_fn(bit [31:0] a);
    return {a[31:4], 4'h0} ^ 32'hC3A5_0F1E;
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", phase, what, act, exp);
    end
  endtask

  task automatic tick();
    bit        hit_now;
    bit [31:0] hdat;
    int        idx, vic;
    bit        do_fill;
    fill_ack_i = 1'b0;
    if (m_fill) begin
      if (wait_n >= lat) begin
        fill_ack_i  = 1'b1;
        fill_data_i = mem_fn(m_faddr);
      end else wait_n++;
    end
    e_rv = 0;
    do_fill = 0;
    vic = 0;
    if (!m_fill && fetch_req_i) begin
      idx = int'(fetch_addr_i[7:4]);
      hit_now = 0;
      hdat = '0;
      for (int w = 0; w < 4; w++)
        if (m_val[idx][w] && m_tag[idx][w] == fetch_addr_i[31:8]) begin
          hit_now = 1; hdat = m_dat[idx][w];
        end
      if (hit_now) begin
        e_rv = 1; e_hit = 1; e_data = hdat;
      end else begin
        m_fill = 1; m_faddr = {fetch_addr_i[31:4], 4'h0}; wait_n = 0;
      end
    end else if (m_fill && fill_ack_i) begin
      idx = int'(m_faddr[7:4]);
      vic = -1;
      for (int w = 0; w < 4; w++) if (!m_val[idx][w] && vic < 0) vic = w;
      if (vic < 0) vic = m_cnt;
      do_fill = 1;
      e_rv = 1; e_hit = 0; e_data = fill_data_i;
    end
    // commands act on pre-edge contents (R7, R8); fill write follows (R10)
    if (cmd_valid_i && cmd_op_i == 2'b11) begin
      for (int s = 0; s < 16; s++) for (int w = 0; w < 4; w++) m_val[s][w] = 0;
    end else if (cmd_valid_i && (cmd_op_i == 2'b01 || cmd_op_i == 2'b10)) begin
      for (int w = 0; w < 4; w++)
        if (m_val[cmd_addr_i[7:4]][w] && m_tag[cmd_addr_i[7:4]][w] == cmd_addr_i[31:8])
          m_val[cmd_addr_i[7:4]][w] = 0;
    end
    if (do_fill) begin
      idx = int'(m_faddr[7:4]);
      m_val[idx][vic] = 1; m_tag[idx][vic] = m_faddr[31:8]; m_dat[idx][vic] = fill_data_i;
      m_fill = 0;
    end
    @(posedge clk_i);
    #1;
    m_cnt = (m_cnt + 1) % 4;
    fill_ack_i = 1'b0;
    chk("ready", fetch_ready_o, !m_fill);
    chk("rsp_valid", fetch_valid_o, e_rv);
    if (e_rv) begin
      chk("rsp_hit", fetch_hit_o, e_hit);
      chk("rsp_data", fetch_data_o, e_data);
    end
    chk("fill_req", fill_req_o, m_fill);
    if (m_fill) chk("fill_addr", fill_addr_o, m_faddr);
  endtask

  task automatic fetch(input logic [31:0] a);
    fetch_req_i = 1'b1; fetch_addr_i = a;
    tick();
    fetch_req_i = 1'b0;
    while (m_fill) tick();
    tick();
  endtask

  task automatic cmd(input logic [1:0] op, input logic [31:0] a);
    cmd_valid_i = 1'b1; cmd_op_i = op; cmd_addr_i = a;
    tick();
    cmd_valid_i = 1'b0; cmd_op_i = 2'b00;
  endtask

  function automatic logic [31:0] la(int t, int s);
    return {24'(t), 4'(s), 4'h0};
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 16; s++) for (int w = 0; w < 4; w++) m_val[s][w] = 0;
    // R1: reset values
    #22;
    chk("reset_ready", fetch_ready_o, 1);
    chk("reset_valid", fetch_valid_o, 0);
    chk("reset_fill", fill_req_o, 0);
    @(posedge clk_i); #1;
    rst_ni = 1'b1;
    tick();

    // R3: cold misses at several latencies; R2: refetch hits, offset ignored
    phase = "R3";
    lat = 2; fetch(la(1, 1));
    lat = 0; fetch(la(2, 3));
    lat = 3; fetch(la(3, 5) | 32'h8);
    phase = "R2";
    fetch(la(1, 1)); fetch(la(2, 3) | 32'hC); fetch(la(3, 5));

    // R5: empty ways first, then counter choice; R6: evicted line misses
    phase = "R5";
    lat = 1;
    for (int t = 10; t < 14; t++) fetch(la(t, 2));
    fetch(la(20, 2));
    lat = 2; fetch(la(21, 2));
    phase = "R6";
    for (int t = 10; t < 14; t++) fetch(la(t, 2));
    fetch(la(20, 2)); fetch(la(21, 2));

    // R7: single-line invalidate and push, absent line, no-op
    phase = "R7";
    cmd(2'b01, la(1, 1)); fetch(la(1, 1));
    cmd(2'b10, la(2, 3)); fetch(la(2, 3));
    cmd(2'b10, la(99, 5)); fetch(la(3, 5));
    cmd(2'b01, la(3, 6)); fetch(la(3, 5));
    cmd(2'b00, la(3, 5)); fetch(la(3, 5));

    // R9: snoop reads and writes at cached lines change nothing
    phase = "R9";
    for (int k = 0; k < 6; k++) begin
      snoop_valid_i = 1'b1; snoop_write_i = k[0]; snoop_addr_i = (k < 3) ? la(3, 5) : la(1, 1);
      tick();
    end
    snoop_valid_i = 1'b0;
    fetch(la(3, 5)); fetch(la(1, 1));

    // R8: invalidate all
    phase = "R8";
    cmd(2'b11, '0);
    fetch(la(3, 5)); fetch(la(1, 1)); fetch(la(20, 2));

    // R10: command with a hitting fetch sees old contents; command across a fill
    phase = "R10";
    cmd_valid_i = 1'b1; cmd_op_i = 2'b01; cmd_addr_i = la(3, 5);
    fetch_req_i = 1'b1; fetch_addr_i = la(3, 5);
    tick();
    fetch_req_i = 1'b0; cmd_valid_i = 1'b0;
    tick();
    fetch(la(3, 5));
    lat = 3;
    cmd_valid_i = 1'b1; cmd_op_i = 2'b11;
    fetch(la(40, 7));
    cmd_valid_i = 1'b0;
    fetch(la(40, 7)); fetch(la(3, 5));
    lat = 0;
    cmd_valid_i = 1'b1; cmd_op_i = 2'b01; cmd_addr_i = la(41, 7);
    fetch(la(41, 7));
    cmd_valid_i = 1'b0;
    fetch(la(41, 7));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule